// File: doc/BRIEF.md
# Zero-Overhead Loop Pipeline Sequencer

This block is the control section of a small soft-decision decoding processor. It fetches one 8-bit instruction per cycle from a program memory port and moves each one through five stages: fetch, decode, operand fetch, execute and store. At the store stage each instruction is presented on a retire record together with its program counter and two symbol addresses. Operative work is not performed here. Operative instructions leave the block as a strobe with a 6-bit operation code, and execution units downstream act on that strobe.

Three control instructions are handled inside the block. A size instruction sets the sub-block length, up to 64 symbols. A loop instruction repeats the short body that follows it. The repeat count is not encoded in the instruction: it is taken as half the sub-block length, so that one pass of a two-sided (butterfly) sweep covers the whole block. A branch instruction jumps to an absolute address.

Loop-back costs no cycles, because the fetch address is redirected while the last body instruction is being fetched. A taken branch is resolved one stage later and leaves exactly one empty slot.

The block also keeps two symbol address counters, one per recursion direction. The forward counter runs up from zero. The backward counter runs down from the last symbol. Both step once per loop iteration and travel down the pipeline with every instruction.

Top module: `zol_seq`

## Requirements
- R1: While reset is low, and for the first three cycles after it is released, `ret_valid` and `op_stb` are low. The instruction at address 0 retires on the fourth cycle after release, and each fetched instruction reaches the retire outputs four cycles after its fetch.
- R2: Instructions retire in execution order with their own address and unchanged 8-bit word. `op_stb` is high exactly when a retiring word has bits [7:6] = 00, and `op_code` then carries bits [5:0].
- R3: A word with bit 7 = 1 loads the sub-block size from bits [6:0], saturated to 64. The size after reset is 64.
- R4: A word with bits [7:5] = 010 and length L = bits [4:0] other than 0 runs the L instructions that follow it max(size/2, 1) times, with size/2 rounded down. Execution then continues at the loop address + L + 1. A word with L = 0 acts as an ordinary instruction.
- R5: Between the last body instruction of one iteration and the first body instruction of the next, no empty slot appears at the retire outputs.
- R6: A word with bits [7:5] = 011 jumps to the absolute address in bits [4:0]. Exactly one empty retire slot follows it, the instruction after it never retires, and any active loop is cancelled.
- R7: When a loop starts, the forward address becomes 0 and the backward address becomes size-1 (0 when size is 0). Each time the last body instruction is fetched, forward steps +1 and backward steps -1, both modulo 128. Each retiring instruction carries the pair that was current when it was fetched.
- R8: A size, loop or branch word that sits in the slot cancelled by a taken branch has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rom_addr | output | 5 | Program memory read address (fetch PC) |
| rom_data | input | 8 | Program memory word at `rom_addr`, same cycle |
| ret_valid | output | 1 | Store stage holds a real instruction |
| ret_pc | output | 5 | Address of the retiring instruction |
| ret_ins | output | 8 | Word of the retiring instruction |
| ret_fwd | output | 7 | Forward symbol address carried with it |
| ret_bwd | output | 7 | Backward symbol address carried with it |
| op_stb | output | 1 | Retiring instruction is of the operative class |
| op_code | output | 6 | Operative code, zero when `op_stb` is low |

## Verification
A wrong loop start, loop end or iteration count shows at the retire port four cycles later. It appears as an address in `ret_pc` that breaks the expected sequence. A miscounted remaining trip count only shows when the loop should end, which can be up to 32 iterations late, so long loops are run to completion. A wrong size register or address counter appears in `ret_fwd` and `ret_bwd` on the first body instruction after the next loop start. A missing or extra flush appears as a missing or extra empty retire slot right behind the branch.

// File: rtl/zol_pkg.sv
package zol_pkg;
  localparam int PC_W     = 5;
  localparam int SIZE_MAX = 64;
  localparam int SZ_W     = $clog2(SIZE_MAX + 1);
  localparam int IW       = 8;
  localparam int LEN_W    = 5;
  localparam int OPC_W    = 6;
  localparam int NPIPE    = 4;

  typedef enum logic [1:0] {K_OP, K_LOOP, K_BR, K_SET} kind_e;

  typedef struct packed {
    logic            v;
    logic [IW-1:0]   ins;
    logic [PC_W-1:0] pc;
    logic [SZ_W-1:0] fw;
    logic [SZ_W-1:0] bw;
  } stage_t;

  function automatic kind_e kind_of(input logic [IW-1:0] w);
    if (w[7])                kind_of = K_SET;
    else if (w[6:5] == 2'b10) kind_of = K_LOOP;
    else if (w[6:5] == 2'b11) kind_of = K_BR;
    else                     kind_of = K_OP;
  endfunction

  function automatic logic [SZ_W-1:0] sat_size(input logic [6:0] imm);
    if (int'(imm) > SIZE_MAX) sat_size = SZ_W'(SIZE_MAX);
    else                      sat_size = SZ_W'(imm);
  endfunction

  function automatic logic [SZ_W-1:0] trip_of(input logic [SZ_W-1:0] sz);
    logic [SZ_W-1:0] h;
    h = sz >> 1;
    trip_of = (h == '0) ? SZ_W'(1) : h;
  endfunction

  function automatic logic [SZ_W-1:0] bwd_start(input logic [SZ_W-1:0] sz);
    bwd_start = (sz == '0) ? '0 : sz - SZ_W'(1);
  endfunction
endpackage

// File: rtl/zol_fetch.sv
module zol_fetch import zol_pkg::*; (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IW-1:0]   rom_data,
  input  logic            flush,
  input  logic [PC_W-1:0] br_tgt,
  output logic [PC_W-1:0] pc,
  output stage_t          f_rec,
  output logic            wrap,
  output logic            arm,
  output logic            loop_act,
  output logic [PC_W-1:0] lp_start,
  output logic [SZ_W-1:0] left,
  output logic [SZ_W-1:0] fwd,
  output logic [SZ_W-1:0] bwd,
  output logic [SZ_W-1:0] size_q
);
  kind_e           kind;
  logic [PC_W-1:0] lp_end;
  logic            at_end;
  logic            step;
  logic            finish;
  logic [PC_W-1:0] pc_nxt;

  always_comb begin
    kind   = kind_of(rom_data);
    at_end = loop_act && (pc == lp_end);
    arm    = !flush && (kind == K_LOOP) && (rom_data[LEN_W-1:0] != '0);
    step   = !flush && !arm && at_end;
    wrap   = step && (left > SZ_W'(1));
    finish = step && (left <= SZ_W'(1));
    if (flush)     pc_nxt = br_tgt;
    else if (wrap) pc_nxt = lp_start;
    else           pc_nxt = pc + PC_W'(1);
    f_rec = '{v: !flush, ins: rom_data, pc: pc, fw: fwd, bw: bwd};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc       <= '0;
      loop_act <= 1'b0;
      lp_start <= '0;
      lp_end   <= '0;
      left     <= '0;
      fwd      <= '0;
      bwd      <= '0;
      size_q   <= SZ_W'(SIZE_MAX);
    end else begin
      pc <= pc_nxt;
      if (flush) begin
        loop_act <= 1'b0;
      end else if (arm) begin
        loop_act <= 1'b1;
        lp_start <= pc + PC_W'(1);
        lp_end   <= pc + PC_W'(rom_data[LEN_W-1:0]);
        left     <= trip_of(size_q);
        fwd      <= '0;
        bwd      <= bwd_start(size_q);
      end else begin
        if (step) begin
          fwd <= fwd + SZ_W'(1);
          bwd <= bwd - SZ_W'(1);
        end
        if (wrap)   left     <= left - SZ_W'(1);
        if (finish) loop_act <= 1'b0;
      end
      if (!flush && kind == K_SET) size_q <= sat_size(rom_data[6:0]);
    end
  end
endmodule

// File: rtl/zol_pipe_reg.sv
module zol_pipe_reg import zol_pkg::*; (
  input  logic   clk,
  input  logic   rst_n,
  input  stage_t d,
  output stage_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= d;
  end
endmodule

// File: rtl/zol_branch.sv
module zol_branch import zol_pkg::*; (
  input  logic            d_valid,
  input  logic [IW-1:0]   d_ins,
  output logic            flush,
  output logic [PC_W-1:0] br_tgt
);
  always_comb begin
    flush  = d_valid && (kind_of(d_ins) == K_BR);
    br_tgt = PC_W'(d_ins[LEN_W-1:0]);
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq import zol_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PC_W-1:0]  rom_addr,
  input  logic [IW-1:0]    rom_data,
  output logic             ret_valid,
  output logic [PC_W-1:0]  ret_pc,
  output logic [IW-1:0]    ret_ins,
  output logic [SZ_W-1:0]  ret_fwd,
  output logic [SZ_W-1:0]  ret_bwd,
  output logic             op_stb,
  output logic [OPC_W-1:0] op_code
);
  stage_t          pipe [0:NPIPE];
  logic            flush;
  logic [PC_W-1:0] br_tgt;
  logic [PC_W-1:0] pc;
  logic            wrap;
  logic            arm;
  logic            loop_act;
  logic [PC_W-1:0] lp_start;
  logic [SZ_W-1:0] left;
  logic [SZ_W-1:0] fwd;
  logic [SZ_W-1:0] bwd;
  logic [SZ_W-1:0] size_q;
  logic            d_valid;

  zol_fetch u_fetch (
    .clk(clk), .rst_n(rst_n), .rom_data(rom_data), .flush(flush),
    .br_tgt(br_tgt), .pc(pc), .f_rec(pipe[0]), .wrap(wrap), .arm(arm),
    .loop_act(loop_act), .lp_start(lp_start), .left(left), .fwd(fwd),
    .bwd(bwd), .size_q(size_q)
  );

  genvar gi;
  generate
    for (gi = 0; gi < NPIPE; gi++) begin : g_stage
      zol_pipe_reg u_reg (.clk(clk), .rst_n(rst_n), .d(pipe[gi]), .q(pipe[gi+1]));
    end
  endgenerate

  assign d_valid = pipe[1].v;

  zol_branch u_br (
    .d_valid(d_valid), .d_ins(pipe[1].ins), .flush(flush), .br_tgt(br_tgt)
  );

  always_comb begin
    rom_addr  = pc;
    ret_valid = pipe[NPIPE].v;
    ret_pc    = pipe[NPIPE].pc;
    ret_ins   = pipe[NPIPE].ins;
    ret_fwd   = pipe[NPIPE].fw;
    ret_bwd   = pipe[NPIPE].bw;
    op_stb    = pipe[NPIPE].v && (kind_of(pipe[NPIPE].ins) == K_OP);
    op_code   = op_stb ? pipe[NPIPE].ins[OPC_W-1:0] : '0;
  end
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk import zol_pkg::*; (
  input logic            clk,
  input logic            rst_n,
  input logic            flush,
  input logic [PC_W-1:0] br_tgt,
  input logic            d_valid,
  input logic [PC_W-1:0] pc,
  input logic            wrap,
  input logic            arm,
  input logic [PC_W-1:0] lp_start,
  input logic [SZ_W-1:0] fwd,
  input logic [SZ_W-1:0] bwd,
  input logic [SZ_W-1:0] size_q,
  input logic            loop_act,
  input logic [SZ_W-1:0] left,
  input logic            op_stb,
  input logic            ret_valid
);
  AST_FLUSH_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n) flush |=> !d_valid); // R6
  AST_BR_TARGET: assert property (@(posedge clk) disable iff (!rst_n) flush |=> pc == $past(br_tgt)); // R6
  AST_SIZE_CAP: assert property (@(posedge clk) disable iff (!rst_n) int'(size_q) <= SIZE_MAX); // R3
  AST_WRAP_TARGET: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> pc == $past(lp_start)); // R5
  AST_FWD_STEP: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> fwd == $past(fwd) + SZ_W'(1)); // R7
  AST_BWD_STEP: assert property (@(posedge clk) disable iff (!rst_n) wrap |=> bwd == $past(bwd) - SZ_W'(1)); // R7
  AST_ARM_INIT: assert property (@(posedge clk) disable iff (!rst_n) arm |=> fwd == '0); // R7
  AST_LOOP_LEFT: assert property (@(posedge clk) disable iff (!rst_n) loop_act |-> left != '0); // R4
  AST_OP_VALID: assert property (@(posedge clk) disable iff (!rst_n) op_stb |-> ret_valid); // R2
endmodule

bind zol_seq zol_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .br_tgt(br_tgt), .d_valid(d_valid),
  .pc(pc), .wrap(wrap), .arm(arm), .lp_start(lp_start), .fwd(fwd), .bwd(bwd),
  .size_q(size_q), .loop_act(loop_act), .left(left), .op_stb(op_stb),
  .ret_valid(ret_valid)
);

// File: tb/zol_seq_test.sv
module zol_seq_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [4:0] rom_addr;
  logic [7:0] rom_data;
  logic       ret_valid;
  logic [4:0] ret_pc;
  logic [7:0] ret_ins;
  logic [6:0] ret_fwd;
  logic [6:0] ret_bwd;
  logic       op_stb;
  logic [5:0] op_code;

  logic [7:0] rom [32];
  assign rom_data = rom[rom_addr];

  always #10 clk = ~clk;

  zol_seq uut (
    .clk(clk), .rst_n(rst_n), .rom_addr(rom_addr), .rom_data(rom_data),
    .ret_valid(ret_valid), .ret_pc(ret_pc), .ret_ins(ret_ins),
    .ret_fwd(ret_fwd), .ret_bwd(ret_bwd), .op_stb(op_stb), .op_code(op_code)
  );

  typedef struct {
    bit    bub;
    int    pc;
    int    ins;
    int    fw;
    int    bw;
    string tag;
  } item_t;

  item_t q[$];
  int    nchk = 0;
  int    nfail = 0;
  bit    armed = 1'b0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] w_set(input int n);  return 8'(128 + n); endfunction
  function automatic logic [7:0] w_loop(input int l); return 8'(64 + l);  endfunction
  function automatic logic [7:0] w_br(input int t);   return 8'(96 + t);  endfunction

  task automatic clear_rom();
    for (int i = 0; i < 32; i++) rom[i] = 8'(i % 8);
  endtask

  // Reference model in program order: queues retire items and empty slots
  task automatic model(input int nf, input string tag);
    int pc, npc, sz, act, st, en, left, fw, bw, n, ins;
    bit wr, br;
    item_t it;
    pc = 0; sz = 64; act = 0; st = 0; en = 0; left = 0; fw = 0; bw = 0; n = 0; wr = 0;
    while (n < nf) begin
      ins = int'(rom[pc]);
      npc = (pc + 1) % 32;
      br = 0;
      it.bub = 0; it.pc = pc; it.ins = ins; it.fw = fw; it.bw = bw;
      it.tag = wr ? "R5" : tag;
      q.push_back(it);
      n++;
      wr = 0;
      if ((ins >> 5) == 2 && (ins % 32) != 0) begin
        st = (pc + 1) % 32; en = (pc + ins % 32) % 32;
        left = sz / 2; if (left == 0) left = 1;
        act = 1; fw = 0; bw = (sz == 0) ? 0 : sz - 1;
      end else if (act == 1 && pc == en) begin
        fw = (fw + 1) % 128; bw = (bw + 127) % 128;
        if (left > 1) begin left--; npc = st; wr = 1; end
        else act = 0;
      end
      if (ins >= 128) begin sz = ins - 128; if (sz > 64) sz = 64; end
      if ((ins >> 5) == 3) begin npc = ins % 32; act = 0; wr = 0; br = 1; end
      if (br) begin
        it.bub = 1; it.tag = "R6";
        q.push_back(it);
      end
      pc = npc;
    end
  endtask

  // Monitor: one expected item per cycle once armed
  always @(negedge clk) begin
    if (armed && q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      if (it.bub) begin
        check(ret_valid == 1'b0, "R6", "empty slot after branch", int'(ret_valid), 0);
      end else begin
        check(ret_valid == 1'b1, it.tag, "valid", int'(ret_valid), 1);
        check(int'(ret_pc) == it.pc, it.tag, "pc", int'(ret_pc), it.pc);
        check(int'(ret_ins) == it.ins, it.tag, "word", int'(ret_ins), it.ins);
        check(int'(ret_fwd) == it.fw, "R7", "forward addr", int'(ret_fwd), it.fw);
        check(int'(ret_bwd) == it.bw, "R7", "backward addr", int'(ret_bwd), it.bw);
        check(op_stb == ((it.ins >> 6) == 0), "R2", "op strobe", int'(op_stb),
              int'((it.ins >> 6) == 0));
        if ((it.ins >> 6) == 0)
          check(int'(op_code) == it.ins % 64, "R2", "op code", int'(op_code), it.ins % 64);
      end
    end
  end

  task automatic run(input string tag, input int nf);
    q.delete();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(ret_valid == 1'b0 && op_stb == 1'b0, "R1", "idle in reset", int'(ret_valid), 0);
    rst_n = 1'b1;
    model(nf, tag);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(ret_valid == 1'b0, "R1", "no retire before latency", int'(ret_valid), 0);
    end
    #1 armed = 1'b1;
    while (q.size() > 0) @(negedge clk);
    #1 armed = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    // R4: size 8 gives four passes over a two-instruction body
    clear_rom();
    rom[0] = w_set(8); rom[1] = w_loop(2); rom[2] = 8'd1; rom[3] = 8'd2;
    rom[4] = 8'd3; rom[5] = w_br(0);
    run("R4", 30);

    // R3: size 100 saturates to 64, 32 passes, backward starts at 63
    clear_rom();
    rom[0] = w_set(100); rom[1] = w_loop(1); rom[2] = 8'd5; rom[3] = 8'd6;
    rom[4] = w_br(0);
    run("R3", 45);

    // R4: odd size 7 rounds to 3 passes; a zero-length loop word is ordinary
    clear_rom();
    rom[0] = w_set(7); rom[1] = w_loop(3); rom[2] = 8'd10; rom[3] = 8'd11;
    rom[4] = 8'd12; rom[5] = w_loop(0); rom[6] = 8'd13; rom[7] = w_br(0);
    run("R4", 30);

    // R8: control words in a cancelled slot do nothing; reset size 64 (R3)
    clear_rom();
    rom[0] = w_br(4); rom[1] = w_set(2); rom[2] = w_loop(1); rom[3] = 8'd9;
    rom[4] = w_loop(2); rom[5] = 8'd20; rom[6] = 8'd21; rom[7] = w_br(9);
    rom[8] = w_set(4); rom[9] = w_set(1); rom[10] = w_loop(1); rom[11] = 8'd22;
    rom[12] = w_br(12);
    run("R8", 80);

    // R6: back-to-back branches; size 0 gives one pass with backward 0
    clear_rom();
    rom[0] = w_br(3); rom[3] = w_br(6); rom[6] = w_set(0); rom[7] = w_loop(1);
    rom[8] = 8'd7; rom[9] = w_br(6);
    run("R6", 25);

    // R6: a branch inside a body cancels the loop
    clear_rom();
    rom[0] = w_set(20); rom[1] = w_loop(3); rom[2] = 8'd1; rom[3] = w_br(6);
    rom[4] = 8'd2; rom[5] = 8'd3; rom[6] = 8'd4; rom[7] = 8'd5; rom[8] = w_br(4);
    run("R6", 20);

    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule